// File: doc/BRIEF.md
# Multiprocessor-Capable Serial Port

This block is a full-duplex asynchronous serial port with one transmit path and one receive path. Software writes a byte to start a frame on the transmit line, and reads the most recent accepted byte from the receive buffer. Frames are one low start bit, eight data bits (least significant first), an optional ninth bit, and one high stop bit. The line idles high. All bit timing comes from a tick at sixteen times the bit rate. The tick is either an external pulse input, such as a timer overflow, or an internal divider of the system clock, depending on the selected mode.

In the nine-bit modes the ninth transmitted bit comes from a control input. The ninth received bit is captured next to the receive buffer. In the eight-bit mode the captured bit is the stop bit instead. A filter input makes acceptance conditional. In the nine-bit modes, frames whose ninth bit is 0 are discarded, which lets a node on a shared line ignore data frames that are not addressed to it. In the eight-bit mode, frames with a low stop bit are dropped as framing errors. The transmit-done and receive-done flags stay set until software clears them.

Top module: `mp_serial_port`

## Requirements
- R1: After reset `txd_o` is 1, both flags are 0, and `rx_data_o` and `rx_bit9_o` are 0. A write (`wr_en_i`) while idle starts a frame at once: a start bit of 0, then `wr_data_i` least significant bit first, then in the nine-bit modes `tx_bit9_i`, then a stop bit of 1. Each bit lasts 16 ticks.
- R2: A write that arrives while a frame is being sent is ignored, and the frame in progress is not changed.
- R3: `tx_done_o` is set when the stop bit ends. It stays set until `tx_clr_i` is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R4: The receiver samples each bit on the 8th tick of its bit time (mid-bit). A falling edge whose start bit is high again at mid-bit is discarded, and the receiver goes back to waiting for a start bit.
- R5: With `filter_i` at 0, every frame is accepted. `rx_data_o` takes the eight data bits. `rx_bit9_o` takes the stop bit in the eight-bit mode, or the ninth bit in the nine-bit modes. `rx_done_o` is set.
- R6: In the eight-bit mode with `filter_i` at 1, a frame whose stop bit samples 0 leaves the flag, the buffer and `rx_bit9_o` unchanged.
- R7: In the nine-bit modes with `filter_i` at 1, a frame whose ninth bit is 0 is discarded with no flag and no buffer update. A frame whose ninth bit is 1 is accepted.
- R8: `rx_done_o` stays set until `rx_clr_i` is pulsed. While it is set, frames that arrive are dropped, and `rx_data_o` and `rx_bit9_o` hold their values.
- R9: `mode_i` encoding: 0 is eight-bit with the external tick, 1 is nine-bit with the external tick, and 2 or 3 is nine-bit with the internal tick (one pulse every FIX_DIV clocks). In modes 2 and 3, `tick_i` has no effect. In modes 0 and 1, no bit advances without `tick_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Frame format and tick source select |
| filter_i | input | 1 | Multiprocessor / framing filter enable |
| tx_bit9_i | input | 1 | Ninth bit to transmit in nine-bit modes |
| tick_i | input | 1 | External 16x bit-rate tick pulse |
| wr_en_i | input | 1 | Write strobe for the transmit buffer |
| wr_data_i | input | 8 | Byte to transmit |
| tx_clr_i | input | 1 | Clears the transmit-done flag |
| rx_clr_i | input | 1 | Clears the receive-done flag |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |
| rx_data_o | output | 8 | Last accepted received byte |
| rx_bit9_o | output | 1 | Captured ninth bit or stop bit |

## Verification
The checker watches several properties on every cycle. Both flags must stay set until their clear input arrives. The receive buffer and the captured bit must not change while the receive flag is set. Any newly raised receive flag must come with a captured bit of 1 whenever the filter is on. The transmit line must be high when the transmit flag rises. Other behaviours can only be shown by the bench's scenarios: bit order on the line, the runt start-bit rejection, writes ignored during a frame, and the tick source each mode selects. The bench loops the transmitter back into the receiver, and it also drives hand-built frames with bad stop bits and short glitches.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    FMT8_EXT  = 2'd0,
    FMT9_EXT  = 2'd1,
    FMT9_FIX  = 2'd2,
    FMT9_FIXB = 2'd3
  } sp_mode_e;

  localparam int unsigned OVS = 16;   // ticks per bit
  localparam int unsigned MID = 8;    // tick count at mid-bit

  function automatic logic is_nine(input logic [1:0] m);
    return (m != FMT8_EXT);
  endfunction

  function automatic logic is_fixed(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/sp_tick_sel.sv
module sp_tick_sel #(
  parameter int unsigned FIX_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_fixed,
  input  logic tick_ext,
  output logic tick
);
  localparam int unsigned CW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(FIX_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == TOP);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = use_fixed ? wrap : tick_ext;
endmodule

// File: rtl/sp_tx.sv
module sp_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       nine,
  input  logic       bit9,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       clr,
  output logic       txd,
  output logic       done
);
  logic        busy_q, busy_d;
  logic        nine_q, nine_d;
  logic [10:0] sh_q, sh_d;
  logic [3:0]  bit_q, bit_d;
  logic [3:0]  sub_q, sub_d;
  logic        done_q, done_d;
  logic        fin;
  logic [3:0]  last_bit;

  assign last_bit = nine_q ? 4'd10 : 4'd9;

  always_comb begin
    busy_d = busy_q;
    nine_d = nine_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    sub_d  = sub_q;
    fin    = 1'b0;
    if (!busy_q) begin
      if (wr_en) begin
        busy_d = 1'b1;
        nine_d = nine;
        sh_d   = {1'b1, (nine ? bit9 : 1'b1), wr_data, 1'b0};
        bit_d  = '0;
        sub_d  = '0;
      end
    end else if (tick) begin
      if (sub_q == 4'd15) begin
        sub_d = '0;
        if (bit_q == last_bit) begin
          busy_d = 1'b0;
          fin    = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          sh_d  = {1'b1, sh_q[10:1]};
        end
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
    done_d = fin | (done_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      nine_q <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
      sub_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      nine_q <= nine_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      sub_q  <= sub_d;
      done_q <= done_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign done = done_q;
endmodule

// File: rtl/sp_rx.sv
module sp_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       nine,
  input  logic       filt,
  input  logic       clr,
  output logic [7:0] data,
  output logic       bit9,
  output logic       done
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA} rx_st_e;

  rx_st_e     st_q, st_d;
  logic       s1_q, s2_q;
  logic [3:0] sub_q, sub_d;
  logic [3:0] cnt_q, cnt_d;
  logic [9:0] sh_q, sh_d;
  logic [7:0] data_q, data_d;
  logic       b9_q, b9_d;
  logic       done_q, done_d;
  logic       set;
  logic [3:0] last_cnt;
  logic [7:0] cand_d;
  logic       cand_b;

  assign last_cnt = nine ? 4'd9 : 4'd8;
  assign cand_d   = nine ? sh_d[7:0] : sh_d[8:1];
  assign cand_b   = nine ? sh_d[8]   : sh_d[9];

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    data_d = data_q;
    b9_d   = b9_q;
    set    = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (!s2_q) begin
          st_d  = S_START;
          sub_d = '0;
        end
      end
      S_START: begin
        if (tick) begin
          if (sub_q == 4'(sp_pkg::MID - 1)) begin
            sub_d = '0;
            cnt_d = '0;
            st_d  = s2_q ? S_IDLE : S_DATA;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      default: begin
        if (tick) begin
          if (sub_q == 4'(sp_pkg::OVS - 1)) begin
            sub_d = '0;
            sh_d  = {s2_q, sh_q[9:1]};
            if (cnt_q == last_cnt) begin
              st_d = S_IDLE;
              if ((!filt || cand_b) && !done_q) begin
                set    = 1'b1;
                data_d = cand_d;
                b9_d   = cand_b;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
    endcase
    done_d = set | (done_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      st_q   <= S_IDLE;
      sub_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      data_q <= '0;
      b9_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      st_q   <= st_d;
      sub_q  <= sub_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      data_q <= data_d;
      b9_q   <= b9_d;
      done_q <= done_d;
    end
  end

  assign data = data_q;
  assign bit9 = b9_q;
  assign done = done_q;
endmodule

// File: rtl/mp_serial_port.sv
module mp_serial_port #(
  parameter int unsigned FIX_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       filter_i,
  input  logic       tx_bit9_i,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       tx_clr_i,
  input  logic       rx_clr_i,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       tx_done_o,
  output logic       rx_done_o,
  output logic [7:0] rx_data_o,
  output logic       rx_bit9_o
);
  logic tick;
  logic nine;

  assign nine = sp_pkg::is_nine(mode_i);

  sp_tick_sel #(.FIX_DIV(FIX_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .use_fixed (sp_pkg::is_fixed(mode_i)),
    .tick_ext  (tick_i),
    .tick      (tick)
  );

  sp_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .nine    (nine),
    .bit9    (tx_bit9_i),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .clr     (tx_clr_i),
    .txd     (txd_o),
    .done    (tx_done_o)
  );

  sp_rx u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .rxd   (rxd_i),
    .nine  (nine),
    .filt  (filter_i),
    .clr   (rx_clr_i),
    .data  (rx_data_o),
    .bit9  (rx_bit9_o),
    .done  (rx_done_o)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       filter_i,
  input logic       tx_clr_i,
  input logic       rx_clr_i,
  input logic       txd_o,
  input logic       tx_done_o,
  input logic       rx_done_o,
  input logic [7:0] rx_data_o,
  input logic       rx_bit9_o
);
  p_stop_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done_o) |-> txd_o);

  p_tx_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_o && !tx_clr_i) |=> tx_done_o);

  p_rx_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_o && !rx_clr_i) |=> rx_done_o);

  p_buf_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_o |=> ($stable(rx_data_o) && $stable(rx_bit9_o)));

  p_stop_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done_o) && mode_i == 2'd0 && filter_i) |-> rx_bit9_o);

  p_addr_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done_o) && mode_i != 2'd0 && filter_i) |-> rx_bit9_o);
endmodule

bind mp_serial_port sp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .filter_i  (filter_i),
  .tx_clr_i  (tx_clr_i),
  .rx_clr_i  (rx_clr_i),
  .txd_o     (txd_o),
  .tx_done_o (tx_done_o),
  .rx_done_o (rx_done_o),
  .rx_data_o (rx_data_o),
  .rx_bit9_o (rx_bit9_o)
);

// File: tb/mp_serial_port_test.sv
module mp_serial_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       filt = 1'b0;
  logic       b9 = 1'b0;
  logic       tick;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_clr = 1'b0;
  logic       rx_clr = 1'b0;
  logic       rxd;
  logic       rxd_drv = 1'b1;
  logic       loop = 1'b0;
  logic       gate = 1'b1;
  logic       txd, tx_done, rx_done, rx_b9;
  logic [7:0] rx_data;
  logic [1:0] tdiv = 2'd0;

  int checks = 0;
  int fails  = 0;
  logic [7:0] last_acc = 8'h00;

  always #5 clk = ~clk;

  always @(negedge clk) tdiv <= tdiv + 2'd1;
  assign tick = gate && (tdiv == 2'd3);
  assign rxd  = loop ? txd : rxd_drv;

  mp_serial_port #(.FIX_DIV(4)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .filter_i(filt),
    .tx_bit9_i(b9), .tick_i(tick), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_clr_i(tx_clr), .rx_clr_i(rx_clr), .rxd_i(rxd), .txd_o(txd),
    .tx_done_o(tx_done), .rx_done_o(rx_done), .rx_data_o(rx_data),
    .rx_bit9_o(rx_b9)
  );

  // {mode[1:0], filter, bit9, data[7:0], accept}
  localparam logic [12:0] VEC [7] = '{
    {2'd0, 1'b0, 1'b0, 8'hA5, 1'b1},
    {2'd0, 1'b1, 1'b0, 8'h3C, 1'b1},
    {2'd1, 1'b0, 1'b0, 8'h81, 1'b1},
    {2'd1, 1'b1, 1'b0, 8'h7E, 1'b0},
    {2'd1, 1'b1, 1'b1, 8'h5A, 1'b1},
    {2'd2, 1'b1, 1'b1, 8'hC3, 1'b1},
    {2'd2, 1'b1, 1'b0, 8'h0F, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    tx_clr = 1'b1; rx_clr = 1'b1;
    clocks(1);
    tx_clr = 1'b0; rx_clr = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    clocks(1);
    wr_en = 1'b0;
  endtask

  // samples nb bits of the line at mid-bit after a write
  task automatic grab(input int nb, output logic [10:0] got);
    got = '1;
    clocks(31);
    for (int k = 0; k < nb; k++) begin
      got[k] = txd;
      if (k != nb - 1) clocks(64);
    end
  endtask

  task automatic drive_frame(input logic [10:0] bits, input int nb, input int stop_len);
    for (int k = 0; k < nb; k++) begin
      rxd_drv = bits[k];
      clocks((k == nb - 1) ? stop_len : 64);
    end
    rxd_drv = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [10:0] got, exp;
    int nb;
    clocks(3);
    rst_n = 1'b1;
    clocks(2);
    // R1 reset state
    chk(txd === 1'b1 && tx_done === 1'b0 && rx_done === 1'b0, "R1 reset",
        {txd, tx_done, rx_done}, 3'b100);
    chk(rx_data === 8'h00 && rx_b9 === 1'b0, "R1 reset buffer", {rx_b9, rx_data}, 0);

    // vector table, transmitter looped into receiver
    loop = 1'b1;
    for (int i = 0; i < 7; i++) begin
      logic [1:0] vm; logic vf, vb, va; logic [7:0] vd; logic eb9;
      {vm, vf, vb, vd, va} = VEC[i];
      mode = vm; filt = vf; b9 = vb;
      gate = (vm[1] == 1'b0);   // R9: fixed modes must run with tick_i off
      pulse_clr();
      do_write(vd);
      nb  = (vm == 2'd0) ? 10 : 11;
      exp = (vm == 2'd0) ? {1'b1, 1'b1, vd, 1'b0} : {1'b1, vb, vd, 1'b0};
      grab(nb, got);
      chk(got == exp, "R1/R9 frame on line", got, exp);
      chk(tx_done === 1'b0, "R3 flag low during stop", tx_done, 0);
      clocks(40);
      chk(tx_done === 1'b1, "R3 flag after stop", tx_done, 1);
      chk(rx_done === va, "R5/R6/R7 accept", rx_done, va);
      eb9 = (vm == 2'd0) ? 1'b1 : vb;
      if (va) begin
        chk(rx_data === vd && rx_b9 === eb9, "R5 buffer", {rx_b9, rx_data}, {eb9, vd});
        last_acc = vd;
      end else begin
        chk(rx_data === last_acc, "R7 buffer kept", rx_data, last_acc);
      end
    end
    gate = 1'b1;

    // R2: write during a frame is ignored
    mode = 2'd0; filt = 1'b0;
    pulse_clr();
    do_write(8'h55);
    clocks(100);
    do_write(8'hAA);
    clocks(700);
    chk(rx_data === 8'h55, "R2 second write ignored", rx_data, 8'h55);
    // R3 flag sticky long after, then cleared, no second frame follows
    clocks(500);
    chk(tx_done === 1'b1, "R3 sticky", tx_done, 1);
    pulse_clr();
    clocks(800);
    chk(tx_done === 1'b0 && txd === 1'b1, "R3 cleared, line idle", {tx_done, txd}, 2'b01);

    // R9: external-tick mode stalls without tick_i
    mode = 2'd1; gate = 1'b0;
    do_write(8'h00);
    clocks(200);
    chk(txd === 1'b0, "R9 stalled without tick", txd, 0);
    gate = 1'b1;
    clocks(800);
    chk(tx_done === 1'b1, "R9 resumes with tick", tx_done, 1);

    // R4: runt start bit
    loop = 1'b0; mode = 2'd0; filt = 1'b0;
    pulse_clr();
    rxd_drv = 1'b0; clocks(16); rxd_drv = 1'b1;
    clocks(800);
    chk(rx_done === 1'b0, "R4 glitch ignored", rx_done, 0);
    drive_frame({1'b1, 1'b1, 8'h96, 1'b0}, 10, 64);
    clocks(20);
    chk(rx_done === 1'b1 && rx_data === 8'h96, "R4 recovery", {rx_done, rx_data}, {1'b1, 8'h96});

    // R8: buffer held while flag set
    drive_frame({1'b1, 1'b1, 8'h11, 1'b0}, 10, 64);
    clocks(20);
    chk(rx_data === 8'h96 && rx_done === 1'b1, "R8 overrun dropped", rx_data, 8'h96);
    pulse_clr();
    chk(rx_done === 1'b0, "R8 clear", rx_done, 0);

    // R6: framing error filtered in eight-bit mode
    filt = 1'b1;
    drive_frame({1'b1, 1'b0, 8'h22, 1'b0}, 10, 40);
    clocks(100);
    chk(rx_done === 1'b0 && rx_data === 8'h96, "R6 bad stop dropped", {rx_done, rx_data}, {1'b0, 8'h96});
    // R5: same frame with filter off is accepted, stop captured as 0
    filt = 1'b0;
    drive_frame({1'b1, 1'b0, 8'h22, 1'b0}, 10, 40);
    clocks(100);
    chk(rx_done === 1'b1 && rx_data === 8'h22 && rx_b9 === 1'b0, "R5 stop captured",
        {rx_done, rx_b9, rx_data}, {1'b1, 1'b0, 8'h22});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule